// File: doc/BRIEF.md
# Reservation-Wait Stall Controller

This block sits next to a simple in-order core and executes the two wait-on-reservation instructions. One variant waits with no timeout. The other waits with a short built-in timeout. When a matching instruction issues while the load-reserved logic still holds a valid reservation, the block raises `stall_o` to freeze the hart. It keeps the hart frozen until a release event occurs. Release events are: the reservation is lost, any interrupt becomes pending, the short timeout expires (short variant only), or the core asks for an early release.

A supervisor may ask for long waits to be bounded. In that case the no-timeout variant, executed below machine mode, can run past a bounded limit. The block then ends the wait with an illegal-instruction exception, or with a virtual-instruction exception when the request came from the virtualization layer. Every wait ends with exactly one one-cycle pulse: either `retire_o`, or `excp_o` together with a cause code.

Top module: `wrs_stall_ctrl`

## Requirements
- R1: An instruction is accepted only when `insn_valid_i` is high while idle and the word has opcode 0x73, rd=0, funct3=0, rs1=0 and funct12 0x00D (no-timeout) or 0x01D (short-timeout). Any other word is ignored: `stall_o`, `retire_o` and `excp_o` stay low.
- R2: If `rsv_valid_i` is low in the issue cycle, `retire_o` pulses in the next cycle and `stall_o` never rises.
- R3: If `rsv_valid_i` is high in the issue cycle, `stall_o` is high from the next cycle and stays high until a release or a trap.
- R4: While stalled, `rsv_valid_i` low in a cycle ends the stall. In the next cycle `stall_o` is low and `retire_o` pulses.
- R5: While stalled, any nonzero `irq_pend_i` ends the stall the same way as R4. The block has no notion of interrupt enables.
- R6: While stalled, `spurious_i` high ends the stall the same way as R4.
- R7: The short-timeout variant stays stalled for at most `STO_CYCLES` cycles and then retires. The default of 1000 cycles is 10 us at 100 MHz.
- R8: In the no-timeout variant with privilege U (2'b00) or S (2'b01) and `tw_i` high, a stall still present after `LIMIT_CYCLES` cycles ends with `excp_o` and cause 2 (illegal instruction).
- R9: In the no-timeout variant with `virt_i` high, privilege U or S, `vtw_i` high and `tw_i` low, the expiry of R8 ends with cause 22 (virtual instruction).
- R10: The trap limit never applies to the short-timeout variant, in M mode (2'b11), or when neither bit selects it. Both variants are legal in every mode and never trap at issue.
- R11: A release condition in the same cycle as the trap-limit expiry retires the instruction and raises no exception.
- R12: `retire_o` and `excp_o` are one-cycle pulses that are never high together. Each one coincides with the cycle in which `stall_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| priv_i | input | 2 | Privilege mode: 00 U, 01 S, 11 M |
| virt_i | input | 1 | Hart runs virtualized (VS/VU) |
| rsv_valid_i | input | 1 | Reservation set is valid |
| irq_pend_i | input | IRQ_W | Pending interrupt bits, enabled or not |
| tw_i | input | 1 | Bounded-wait trap enable |
| vtw_i | input | 1 | Bounded-wait virtual trap enable |
| spurious_i | input | 1 | Early release request |
| stall_o | output | 1 | Hart is held waiting |
| retire_o | output | 1 | One-cycle retire pulse |
| excp_o | output | 1 | One-cycle exception pulse |
| excp_cause_o | output | CAUSE_W | Exception cause, valid with excp_o |

## Verification
The wait is driven with each release source: reservation loss, interrupts, early release and timeout. Each source is applied at a chosen stall cycle. The measured stall length and the outcome therefore show whether the event was recognised in exactly that cycle. Random trials mix both variants and all privilege, virtualization and trap-bit settings, so a wrongly armed or missing trap shows up as a length or outcome mismatch. Directed cases place a release exactly on the trap limit and on the short timeout, to separate release-wins from trap-wins. Near-miss instruction words check that decoding rejects every other field value.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  localparam logic [6:0]  OPC_SYSTEM = 7'h73;
  localparam logic [11:0] F12_NTO    = 12'h00D;
  localparam logic [11:0] F12_STO    = 12'h01D;

  localparam int unsigned CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'd22;

  localparam logic [1:0] PRIV_M = 2'b11;

  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_ILL  = 2'd1,
    TRAP_VIRT = 2'd2
  } trap_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } state_e;

endpackage

// File: rtl/wrs_decode.sv
module wrs_decode
  import wrs_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        is_nto_o,
  output logic        is_sto_o
);

  logic base_ok;

  always_comb begin
    base_ok  = (insn_i[6:0] == OPC_SYSTEM) && (insn_i[11:7] == 5'd0) &&
               (insn_i[14:12] == 3'd0) && (insn_i[19:15] == 5'd0);
    is_nto_o = base_ok && (insn_i[31:20] == F12_NTO);
    is_sto_o = base_ok && (insn_i[31:20] == F12_STO);
  end

endmodule

// File: rtl/wrs_trap_sel.sv
module wrs_trap_sel
  import wrs_pkg::*;
(
  input  logic       is_nto_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       tw_i,
  input  logic       vtw_i,
  output trap_e      trap_o
);

  logic below_m;

  always_comb begin
    below_m = (priv_i != PRIV_M);
    trap_o  = TRAP_NONE;
    if (is_nto_i && below_m) begin
      if (tw_i)                trap_o = TRAP_ILL;
      else if (virt_i && vtw_i) trap_o = TRAP_VIRT;
    end
  end

endmodule

// File: rtl/wrs_wait_timer.sv
module wrs_wait_timer #(
  parameter int unsigned STO_CYCLES   = 1000,
  parameter int unsigned LIMIT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic sto_hit_o,
  output logic lim_hit_o
);

  localparam int unsigned MAXV  = (STO_CYCLES > LIMIT_CYCLES) ? STO_CYCLES : LIMIT_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAXV + 1);
  localparam logic [CNT_W-1:0] STO_LAST = CNT_W'(STO_CYCLES - 1);
  localparam logic [CNT_W-1:0] LIM_LAST = CNT_W'(LIMIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAXV);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i || (en_i && (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign sto_hit_o = en_i && (cnt_q == STO_LAST);
  assign lim_hit_o = en_i && (cnt_q == LIM_LAST);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

endmodule

// File: rtl/wrs_stall_ctrl.sv
module wrs_stall_ctrl
  import wrs_pkg::*;
#(
  parameter int unsigned IRQ_W        = 12,
  parameter int unsigned STO_CYCLES   = 1000,
  parameter int unsigned LIMIT_CYCLES = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_valid_i,
  input  logic [31:0]        insn_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               rsv_valid_i,
  input  logic [IRQ_W-1:0]   irq_pend_i,
  input  logic               tw_i,
  input  logic               vtw_i,
  input  logic               spurious_i,
  output logic               stall_o,
  output logic               retire_o,
  output logic               excp_o,
  output logic [CAUSE_W-1:0] excp_cause_o
);

  state_e state_q, state_d;
  logic   short_q, short_d;
  trap_e  trap_q, trap_d, trap_sel;
  logic   retire_q, retire_d, excp_q, excp_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;

  logic is_nto, is_sto, issue, release_ev, expire, sto_hit, lim_hit, waiting;

  wrs_decode u_decode (
    .insn_i   (insn_i),
    .is_nto_o (is_nto),
    .is_sto_o (is_sto)
  );

  wrs_trap_sel u_trap_sel (
    .is_nto_i (is_nto),
    .priv_i   (priv_i),
    .virt_i   (virt_i),
    .tw_i     (tw_i),
    .vtw_i    (vtw_i),
    .trap_o   (trap_sel)
  );

  assign waiting = (state_q == ST_WAIT);

  wrs_wait_timer #(
    .STO_CYCLES   (STO_CYCLES),
    .LIMIT_CYCLES (LIMIT_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (!waiting),
    .en_i      (waiting),
    .sto_hit_o (sto_hit),
    .lim_hit_o (lim_hit)
  );

  always_comb begin
    issue      = (state_q == ST_IDLE) && insn_valid_i && (is_nto || is_sto);
    release_ev = !rsv_valid_i || (|irq_pend_i) || spurious_i || (short_q && sto_hit);
    expire     = (trap_q != TRAP_NONE) && lim_hit;

    state_d  = state_q;
    short_d  = short_q;
    trap_d   = trap_q;
    retire_d = 1'b0;
    excp_d   = 1'b0;
    cause_d  = cause_q;

    unique case (state_q)
      ST_IDLE: begin
        if (issue) begin
          if (rsv_valid_i) begin
            state_d = ST_WAIT;
            short_d = is_sto;
            trap_d  = trap_sel;
          end else begin
            retire_d = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (release_ev) begin
          state_d  = ST_IDLE;
          retire_d = 1'b1;
        end else if (expire) begin
          state_d = ST_IDLE;
          excp_d  = 1'b1;
          cause_d = (trap_q == TRAP_VIRT) ? CAUSE_VIRT : CAUSE_ILLEGAL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      short_q  <= 1'b0;
      trap_q   <= TRAP_NONE;
      retire_q <= 1'b0;
      excp_q   <= 1'b0;
      cause_q  <= '0;
    end else begin
      state_q  <= state_d;
      retire_q <= retire_d;
      excp_q   <= excp_d;
      if (issue)  short_q <= short_d;
      if (issue)  trap_q  <= trap_d;
      if (excp_d) cause_q <= cause_d;
    end
  end

  assign stall_o      = waiting;
  assign retire_o     = retire_q;
  assign excp_o       = excp_q;
  assign excp_cause_o = cause_q;

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_o && excp_o));
  // R12
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> (retire_o || excp_o));
  // R2
  immediate_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && insn_valid_i && (is_nto || is_sto) && !rsv_valid_i) |=> (retire_o && !stall_o));
  // R4
  rsv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !rsv_valid_i) |=> (!stall_o && retire_o));
  // R5
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && (|irq_pend_i)) |=> (!stall_o && retire_o));
  // R6
  spur_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && spurious_i) |=> (!stall_o && retire_o));
  // R8
  cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excp_o |-> (excp_cause_o == CAUSE_ILLEGAL || excp_cause_o == CAUSE_VIRT));
  // R10
  no_short_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excp_o |-> $past(stall_o && !short_q));

endmodule

// File: tb/wrs_stall_ctrl_tb.sv
module wrs_stall_ctrl_tb;

  localparam int IRQ_W = 12;
  localparam int STO   = 12;
  localparam int LIM   = 20;
  localparam logic [31:0] W_NTO = {12'h00D, 5'd0, 3'd0, 5'd0, 7'h73};
  localparam logic [31:0] W_STO = {12'h01D, 5'd0, 3'd0, 5'd0, 7'h73};

  logic clk = 1'b0;
  logic rst_n;
  logic insn_valid;
  logic [31:0] insn;
  logic [1:0] priv;
  logic virt, rsv_valid, tw, vtw, spurious;
  logic [IRQ_W-1:0] irq_pend;
  logic stall, retire, excp;
  logic [4:0] cause;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wrs_stall_ctrl #(.IRQ_W(IRQ_W), .STO_CYCLES(STO), .LIMIT_CYCLES(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid_i(insn_valid), .insn_i(insn),
    .priv_i(priv), .virt_i(virt), .rsv_valid_i(rsv_valid), .irq_pend_i(irq_pend),
    .tw_i(tw), .vtw_i(vtw), .spurious_i(spurious), .stall_o(stall),
    .retire_o(retire), .excp_o(excp), .excp_cause_o(cause)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int trap_kind(bit nto, logic [1:0] p, bit v, bit t, bit vt);
    if (!nto || p == 2'b11) return 0;
    if (t) return 1;
    if (v && vt) return 2;
    return 0;
  endfunction

  function automatic int limit_of(bit sto, int tk);
    if (sto) return STO;
    if (tk != 0) return LIM;
    return 1 << 30;
  endfunction

  function automatic int exp_len(bit sto, int tk, int evt);
    int l = limit_of(sto, tk);
    if (evt != 0 && evt <= l) return evt;
    return l;
  endfunction

  function automatic bit exp_trap(bit sto, int tk, int evt);
    int l = limit_of(sto, tk);
    if (evt != 0 && evt <= l) return 1'b0;
    return !sto;
  endfunction

  // evtype: 0 none, 1 reservation loss, 2 interrupt, 3 early release
  task automatic trial(input logic [31:0] w, input logic [1:0] p, input bit v,
                       input bit t, input bit vt, input bit rsv0,
                       input int evtype, input int evt, input string req);
    bit nto = (w == W_NTO);
    bit sto = (w == W_STO);
    int tk  = trap_kind(nto, p, v, t, vt);
    int len = 0;
    int el, ek;
    @(negedge clk);
    insn = w; insn_valid = 1'b1; priv = p; virt = v; tw = t; vtw = vt;
    rsv_valid = rsv0; irq_pend = '0; spurious = 1'b0;
    @(negedge clk);
    insn_valid = 1'b0;
    if (!nto && !sto) begin
      chk(!stall && !retire && !excp, "R1 ignored word", {stall, retire, excp}, 0);
      @(negedge clk);
      chk(!stall && !retire && !excp, "R1 ignored word later", {stall, retire, excp}, 0);
      rsv_valid = 1'b1;
      return;
    end
    if (!rsv0) begin
      chk(retire && !stall && !excp, "R2 immediate retire", {stall, retire, excp}, 3'b010);
      @(negedge clk);
      chk(!retire && !excp, "R12 single pulse", {retire, excp}, 0);
      rsv_valid = 1'b1;
      return;
    end
    chk(stall == 1'b1, "R3 stall raised", stall, 1);
    while (stall && len < 400) begin
      len++;
      if (len == evt) begin
        case (evtype)
          1: rsv_valid = 1'b0;
          2: irq_pend = IRQ_W'($urandom_range(1, (1 << IRQ_W) - 1));
          3: spurious = 1'b1;
          default: ;
        endcase
      end
      @(negedge clk);
    end
    el = exp_len(sto, tk, (evtype == 0) ? 0 : evt);
    ek = exp_trap(sto, tk, (evtype == 0) ? 0 : evt);
    chk(len == el, {req, " stall length"}, len, el);
    if (ek) begin
      chk(excp && !retire, {req, " exception pulse"}, {excp, retire}, 2'b10);
      chk(cause == ((tk == 2) ? 22 : 2), {req, " cause"}, cause, (tk == 2) ? 22 : 2);
    end else begin
      chk(retire && !excp, {req, " retire pulse"}, {retire, excp}, 2'b10);
    end
    rsv_valid = 1'b1; irq_pend = '0; spurious = 1'b0;
    @(negedge clk);
    chk(!retire && !excp && !stall, "R12 pulse one cycle", {stall, retire, excp}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; priv = 2'b00; virt = 1'b0;
    rsv_valid = 1'b1; irq_pend = '0; tw = 1'b0; vtw = 1'b0; spurious = 1'b0;
    repeat (3) @(negedge clk);
    chk(!stall && !retire && !excp, "reset state", {stall, retire, excp}, 0);
    rst_n = 1'b1;

    // R1 near-miss words
    trial(W_NTO | 32'h0000_0080, 2'b00, 0, 0, 0, 1, 1, 3, "R1");
    trial({12'h010, 20'h00073}, 2'b00, 0, 0, 0, 1, 1, 3, "R1");
    trial(W_STO | 32'h0000_8000, 2'b01, 0, 0, 0, 1, 1, 3, "R1");
    // R2
    trial(W_NTO, 2'b00, 0, 1, 0, 0, 1, 1, "R2");
    // R4 R5 R6 releases
    trial(W_NTO, 2'b11, 0, 0, 0, 1, 1, 5, "R4");
    trial(W_NTO, 2'b01, 0, 0, 0, 1, 2, 1, "R5");
    trial(W_STO, 2'b00, 0, 0, 0, 1, 3, 7, "R6");
    // R7 short timeout, and release exactly at the timeout
    trial(W_STO, 2'b01, 1, 1, 1, 1, 0, 0, "R7");
    trial(W_STO, 2'b00, 0, 0, 0, 1, 1, STO, "R7 tie");
    // R8 R9 traps
    trial(W_NTO, 2'b01, 0, 1, 0, 1, 0, 0, "R8");
    trial(W_NTO, 2'b00, 1, 1, 1, 1, 0, 0, "R8 tw in VU");
    trial(W_NTO, 2'b00, 1, 0, 1, 1, 0, 0, "R9");
    // R10 no trap in M mode, bits clear, or without virt
    trial(W_NTO, 2'b11, 0, 1, 1, 1, 2, 30, "R10 M mode");
    trial(W_NTO, 2'b01, 0, 0, 1, 1, 1, 28, "R10 vtw no virt");
    // R11 release on the limit cycle
    trial(W_NTO, 2'b01, 0, 1, 0, 1, 1, LIM, "R11");
    trial(W_NTO, 2'b00, 1, 0, 1, 1, 3, LIM, "R11 virt");

    for (int i = 0; i < 80; i++) begin
      int sel = $urandom_range(0, 4);
      logic [31:0] w;
      logic [1:0] p;
      int pr = $urandom_range(0, 2);
      int et = $urandom_range(0, 3);
      int ev = $urandom_range(1, 30);
      bit v = 1'($urandom_range(0, 1));
      bit t = 1'($urandom_range(0, 1));
      bit vt = 1'($urandom_range(0, 1));
      bit r0 = ($urandom_range(0, 7) != 0);
      p = (pr == 2) ? 2'b11 : 2'(pr);
      if (sel < 2) w = W_NTO;
      else if (sel < 4) w = W_STO;
      else begin
        int b = $urandom_range(0, 31);
        if (b == 24) b = 25;
        w = W_NTO ^ (32'd1 << b);
      end
      if (w == W_NTO && trap_kind(1'b1, p, v, t, vt) == 0 && et == 0) et = 1;
      trial(w, p, v, t, vt, r0, et, ev, "R3 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule